// File: doc/BRIEF.md
# Wiper and Data Register Controller

This block is the register core of a digitally controlled potentiometer. It keeps a 10-bit wiper register, which takes effect at once, and four 10-bit data registers, which stand in for nonvolatile storage. It decodes the wiper value into a one-hot select for 1024 tap switches. A bus slave sits in front of it and hands over decoded commands. Each command carries a 3-bit opcode, a 2-bit register pointer and a 10-bit value, and the value arrives split across a high byte and a low byte. The slave also reports the bus stop condition as a one-cycle strobe.

Writes to the wiper register take effect on the next clock. A write to a data register, or a copy of the wiper into one, is only queued when the command arrives. The bus stop condition starts a timed storage cycle, and the target register is updated when that cycle ends. The write-protect input refuses these storage writes. Leaving reset also takes a one-cycle recall, which copies data register 0 into the wiper. While the recall or a storage cycle is running, `busy` is high and every command is ignored, in the same way a polling master sees no acknowledge.

Top module: `wiper_reg_ctrl`

## Requirements
- R1: `tap_sel` always has exactly one bit set, and that bit is at the index held in the wiper register. Wiper 0 sets bit 0, the low end. Wiper 1023 sets bit 1023, the high end.
- R2: While reset is held, `wiper` is 0 and `busy` is 1. One clock after reset is released, `wiper` equals data register 0 and `busy` is 0. The reset contents of data registers 0 to 3 are 0x200, 0x0AA, 0x3FF and 0x001.
- R3: Opcode 001 loads the wiper with {cmd_hi[1:0], cmd_lo} one clock after the command. Bits cmd_hi[7:2] and the level of `wp_n` have no effect on this.
- R4: Opcode 000 reads the wiper and opcode 010 reads the data register selected by `cmd_ptr`. One clock after the command, `rd_valid` is high for one cycle with rd_hi = {6'b0, value[9:8]} and rd_lo = value[7:0].
- R5: Opcode 011 with `wp_n` high queues {cmd_hi[1:0], cmd_lo} for register `cmd_ptr`. Reading before the stop strobe returns the old contents. After a `bus_stop` strobe, `busy` is high for exactly NV_CYCLES cycles, and the register holds the new value when `busy` falls.
- R6: When `wp_n` is low, opcodes 011 and 101 are refused. A following stop strobe starts no busy cycle, and the data register keeps its old value.
- R7: Opcode 100 copies the data register selected by `cmd_ptr` into the wiper one clock after the command.
- R8: Opcode 101 with `wp_n` high queues the current wiper value for register `cmd_ptr`. It is then committed through the same timed cycle as R5.
- R9: While `busy` is high, commands are ignored. No read response appears and the wiper does not change.
- R10: Opcodes 110 and 111 change no register, give no read response and queue no storage write.
- R11: A stop strobe with no queued storage write leaves `busy` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; its release starts the recall |
| wp_n | input | 1 | Write protect; low refuses data register writes |
| cmd_valid | input | 1 | One-cycle strobe for a decoded command |
| cmd_op | input | 3 | Command opcode |
| cmd_ptr | input | 2 | Data register pointer |
| cmd_hi | input | 8 | High value byte; bits [1:0] are value[9:8] |
| cmd_lo | input | 8 | Low value byte; value[7:0] |
| bus_stop | input | 1 | One-cycle strobe for the bus stop condition |
| busy | output | 1 | High during the recall or a storage cycle |
| rd_valid | output | 1 | Read response strobe |
| rd_hi | output | 8 | Read response high byte |
| rd_lo | output | 8 | Read response low byte |
| wiper | output | 10 | Current wiper register |
| tap_sel | output | 1024 | One-hot tap switch select |

## Verification
The wiper shows up at the ports on every cycle, through `wiper` and through `tap_sel`. A wrong wiper value or a broken decoder is therefore visible one clock after the command that caused it. The bench sweeps all 1024 wiper values to catch this. A data register is only seen through a read, and corruption there waits until the next read of that pointer. For that reason every storage write is followed by read-back of all four registers against a model kept in the bench. A timer that is off by one changes the number of cycles `busy` stays high, so the bench counts those cycles exactly.

// File: rtl/wiper_reg_ctrl.sv
module wiper_reg_ctrl #(
  parameter int W = 10,
  parameter int NV_CYCLES = 500000,
  parameter logic [4*W-1:0] DR_INIT = {10'h001, 10'h3FF, 10'h0AA, 10'h200}
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wp_n,
  input  logic            cmd_valid,
  input  logic [2:0]      cmd_op,
  input  logic [1:0]      cmd_ptr,
  input  logic [7:0]      cmd_hi,
  input  logic [7:0]      cmd_lo,
  input  logic            bus_stop,
  output logic            busy,
  output logic            rd_valid,
  output logic [7:0]      rd_hi,
  output logic [7:0]      rd_lo,
  output logic [W-1:0]    wiper,
  output logic [(1<<W)-1:0] tap_sel
);

  localparam int TAPS = 1 << W;
  localparam int CW   = $clog2(NV_CYCLES + 1);

  localparam logic [2:0] OP_RD_W  = 3'b000;
  localparam logic [2:0] OP_WR_W  = 3'b001;
  localparam logic [2:0] OP_RD_D  = 3'b010;
  localparam logic [2:0] OP_WR_D  = 3'b011;
  localparam logic [2:0] OP_D2W   = 3'b100;
  localparam logic [2:0] OP_W2D   = 3'b101;

  logic [W-1:0]      wcr;
  logic [3:0][W-1:0] dr_q;
  logic              recall_q;
  logic              pend_q;
  logic [1:0]        pend_ptr;
  logic [W-1:0]      pend_val;
  logic [CW-1:0]     nv_cnt;
  logic [W-1:0]      rd_word;

  logic [15:0]  cmd_word;
  logic [W-1:0] cmd_val;
  logic         unused_hi;
  logic         nv_busy;
  logic         take;

  assign cmd_word  = {cmd_hi, cmd_lo};
  assign cmd_val   = cmd_word[W-1:0];
  assign unused_hi = ^cmd_word[15:W];
  assign nv_busy   = nv_cnt != '0;
  assign busy      = nv_busy | recall_q;
  assign take      = cmd_valid & ~busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wcr      <= '0;
      dr_q     <= DR_INIT;
      recall_q <= 1'b1;
      pend_q   <= 1'b0;
      pend_ptr <= '0;
      pend_val <= '0;
      nv_cnt   <= '0;
      rd_valid <= 1'b0;
      rd_word  <= '0;
    end else begin
      rd_valid <= 1'b0;
      if (recall_q) begin
        wcr      <= dr_q[0];
        recall_q <= 1'b0;
      end
      if (nv_busy) begin
        nv_cnt <= nv_cnt - 1'b1;
        if (nv_cnt == CW'(1))
          dr_q[pend_ptr] <= pend_val;
      end else if (bus_stop && pend_q && !recall_q) begin
        nv_cnt <= CW'(NV_CYCLES);
        pend_q <= 1'b0;
      end
      if (take) begin
        case (cmd_op)
          OP_RD_W: begin
            rd_valid <= 1'b1;
            rd_word  <= wcr;
          end
          OP_WR_W: wcr <= cmd_val;
          OP_RD_D: begin
            rd_valid <= 1'b1;
            rd_word  <= dr_q[cmd_ptr];
          end
          OP_WR_D: begin
            pend_q   <= wp_n;
            pend_ptr <= cmd_ptr;
            pend_val <= cmd_val;
          end
          OP_D2W: wcr <= dr_q[cmd_ptr];
          OP_W2D: begin
            pend_q   <= wp_n;
            pend_ptr <= cmd_ptr;
            pend_val <= wcr;
          end
          default: ;
        endcase
      end
    end
  end

  logic [15:0] rd16;
  assign rd16    = 16'(rd_word);
  assign rd_hi   = rd16[15:8];
  assign rd_lo   = rd16[7:0];
  assign wiper   = wcr;
  assign tap_sel = TAPS'(1) << wcr;

  AST_TAP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tap_sel) == 1); // R1
  AST_RECALL_DR0: assert property (@(posedge clk) disable iff (!rst_n)
    recall_q |=> (wiper == $past(dr_q[0]))); // R2
  AST_DR_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !nv_busy |=> $stable(dr_q)); // R5
  AST_WP_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !wp_n && (cmd_op == OP_WR_D || cmd_op == OP_W2D)) |=> !pend_q); // R6
  AST_BUSY_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !rd_valid); // R9
  AST_WIPER_HOLD_NV: assert property (@(posedge clk) disable iff (!rst_n)
    nv_busy |=> $stable(wiper)); // R9

endmodule

// File: tb/wiper_reg_ctrl_tb_top.sv
`timescale 1ns/1ps
module wiper_reg_ctrl_tb_top;
  localparam int NV = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wp_n = 1'b1;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [1:0] cmd_ptr = '0;
  logic [7:0] cmd_hi = '0;
  logic [7:0] cmd_lo = '0;
  logic bus_stop = 1'b0;
  logic busy, rd_valid;
  logic [7:0] rd_hi, rd_lo;
  logic [9:0] wiper;
  logic [1023:0] tap_sel;

  int checks = 0;
  int fails = 0;
  logic [9:0] exp_dr [4];
  logic [9:0] exp_w;

  always #5 clk = ~clk;

  wiper_reg_ctrl #(.W(10), .NV_CYCLES(NV)) dut_i (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_ptr(cmd_ptr), .cmd_hi(cmd_hi), .cmd_lo(cmd_lo),
    .bus_stop(bus_stop), .busy(busy), .rd_valid(rd_valid), .rd_hi(rd_hi),
    .rd_lo(rd_lo), .wiper(wiper), .tap_sel(tap_sel));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [1:0] ptr,
                       input logic [9:0] v, input logic [5:0] junk);
    cmd_valid = 1'b1; cmd_op = op; cmd_ptr = ptr;
    cmd_hi = {junk, v[9:8]}; cmd_lo = v[7:0];
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic stop_strobe();
    bus_stop = 1'b1;
    @(negedge clk);
    bus_stop = 1'b0;
  endtask

  task automatic read_chk(input logic [2:0] op, input logic [1:0] ptr,
                          input logic [9:0] exp, input string req);
    issue(op, ptr, 10'h0, 6'h0);
    chk(rd_valid == 1'b1, req, "rd_valid", 32'(rd_valid), 1);
    chk({rd_hi, rd_lo} == {6'b0, exp}, req, "read data", {16'b0, rd_hi, rd_lo}, 32'(exp));
  endtask

  task automatic all_dr_chk(input string req);
    for (int p = 0; p < 4; p++) read_chk(3'b010, 2'(p), exp_dr[p], req);
  endtask

  task automatic busy_len_chk(input string req);
    int n = 0;
    while (busy && n < 10 * NV) begin
      n++;
      @(negedge clk);
    end
    chk(n == NV, req, "busy cycles", 32'(n), 32'(NV));
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    exp_dr[0] = 10'h200; exp_dr[1] = 10'h0AA; exp_dr[2] = 10'h3FF; exp_dr[3] = 10'h001;
    repeat (3) @(negedge clk);
    // R2 reset state
    chk(busy == 1'b1, "R2", "busy in reset", 32'(busy), 1);
    chk(wiper == 10'h0, "R2", "wiper in reset", 32'(wiper), 0);
    chk(rd_valid == 1'b0, "R4", "rd_valid in reset", 32'(rd_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(wiper == exp_dr[0], "R2", "recall wiper", 32'(wiper), 32'(exp_dr[0]));
    chk(busy == 1'b0, "R2", "busy after recall", 32'(busy), 0);
    chk(tap_sel == (1024'(1) << exp_dr[0]), "R1", "tap after recall", $countones(tap_sel), 1);
    all_dr_chk("R4");

    // R1 R3 sweep of every wiper value, write protect active, junk in high bits
    wp_n = 1'b0;
    for (int v = 0; v < 1024; v++) begin
      issue(3'b001, 2'(v), 10'(v), 6'(v * 7));
      chk(wiper == 10'(v), "R3", "wiper write", 32'(wiper), 32'(v));
      chk(tap_sel == (1024'(1) << v), "R1", "tap select", $countones(tap_sel), 32'(v));
    end
    exp_w = 10'h3FF;
    read_chk(3'b000, 2'd0, exp_w, "R4");
    issue(3'b001, 2'd0, 10'h000, 6'h3F);
    chk(tap_sel[0] == 1'b1 && $countones(tap_sel) == 1, "R1", "low end tap", 32'(tap_sel[0]), 1);
    read_chk(3'b000, 2'd0, 10'h000, "R4");

    // R5 data register writes through the timed cycle
    wp_n = 1'b1;
    for (int k = 0; k < 2; k++) begin
      for (int p = 0; p < 4; p++) begin
        logic [9:0] nv;
        nv = 10'((p * 337 + k * 123 + 5) % 1024);
        issue(3'b011, 2'(p), nv, 6'h2A);
        read_chk(3'b010, 2'(p), exp_dr[p], "R5");
        stop_strobe();
        busy_len_chk("R5");
        exp_dr[p] = nv;
        all_dr_chk("R5");
      end
    end

    // R9 commands ignored during a storage cycle
    issue(3'b001, 2'd0, 10'h155, 6'h0);
    exp_w = 10'h155;
    issue(3'b011, 2'd2, 10'h2C3, 6'h0);
    stop_strobe();
    issue(3'b000, 2'd0, 10'h0, 6'h0);
    chk(rd_valid == 1'b0, "R9", "read while busy", 32'(rd_valid), 0);
    issue(3'b001, 2'd0, 10'h0F0, 6'h0);
    chk(wiper == exp_w, "R9", "write while busy", 32'(wiper), 32'(exp_w));
    while (busy) @(negedge clk);
    exp_dr[2] = 10'h2C3;
    all_dr_chk("R9");

    // R6 write protect refuses storage writes
    wp_n = 1'b0;
    issue(3'b011, 2'd1, 10'h111, 6'h0);
    stop_strobe();
    chk(busy == 1'b0, "R6", "no busy on refused write", 32'(busy), 0);
    issue(3'b101, 2'd3, 10'h0, 6'h0);
    stop_strobe();
    chk(busy == 1'b0, "R6", "no busy on refused copy", 32'(busy), 0);
    all_dr_chk("R6");

    // R7 copy data register into wiper
    for (int p = 0; p < 4; p++) begin
      issue(3'b100, 2'(p), 10'h0, 6'h0);
      chk(wiper == exp_dr[p], "R7", "copy to wiper", 32'(wiper), 32'(exp_dr[p]));
    end

    // R8 copy wiper into data register
    wp_n = 1'b1;
    for (int p = 0; p < 4; p++) begin
      logic [9:0] wv;
      wv = 10'(1023 - p * 100);
      issue(3'b001, 2'd0, wv, 6'h0);
      issue(3'b101, 2'(p), 10'h0, 6'h0);
      stop_strobe();
      busy_len_chk("R8");
      exp_dr[p] = wv;
      all_dr_chk("R8");
    end
    exp_w = 10'(1023 - 300);

    // R10 unused opcodes
    for (int op = 6; op < 8; op++) begin
      issue(3'(op), 2'd1, 10'h3A5, 6'h0);
      chk(rd_valid == 1'b0, "R10", "no read response", 32'(rd_valid), 0);
      chk(wiper == exp_w, "R10", "wiper unchanged", 32'(wiper), 32'(exp_w));
      stop_strobe();
      chk(busy == 1'b0, "R10", "no storage cycle", 32'(busy), 0);
    end
    all_dr_chk("R10");

    // R11 bare stop
    stop_strobe();
    chk(busy == 1'b0, "R11", "bare stop", 32'(busy), 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule